// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen maskable interrupt lines, a non-maskable request and two exception requests, and reports one winner to the processor. Each maskable line is edge-detected into a pending bit and gated by a mask bit. A selection bit per line sends that line to a transaction server instead of a normal service routine. A line routed to the server beats every normal line. The non-maskable request beats both, and the two exceptions beat everything.

The winner is registered. Its 16-bit vector address, its source number and a server/normal flag appear one clock after the state that produced them. The processor acknowledges by naming a source number, which clears that pending bit. A small register port reads and writes the pending, mask and server-select registers.

A receive flag and a transmit flag from a serial port are steered by the mask register. Each goes to its own line when that line is enabled, and otherwise to a shared serial line.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the pending, mask, select and non-maskable pending state, and drives `irq_valid_o`, `irq_to_server_o`, `irq_id_o` and `irq_vector_o` to zero.
- R2: A pending bit is set by a rising edge of its effective request line. A request held high sets it only once. An acknowledge (`ack_i` high, `ack_id_i` = n) clears bit n. A new edge in the same cycle as the acknowledge keeps the bit set.
- R3: The outputs are registered. They reflect the pending, mask, select and exception state one clock after that state changes.
- R4: Among the lines that are pending, enabled and not server-routed, the highest number wins. When nothing qualifies, `irq_valid_o` is 0. A masked pending line never wins.
- R5: A normal winner n reports `irq_to_server_o`=0, `irq_id_o`=n, and a vector of 2000h+2n for n<8 or 2030h+2(n-8) for n>=8.
- R6: Any pending, enabled, server-routed line beats every normal line, with the highest such number winning. It reports `irq_to_server_o`=1 and a vector of 2040h+2n.
- R7: A rising edge on `nmi_i` sets a non-maskable pending flag that ignores the mask. It beats all maskable lines and reports id 15, vector 203Eh and `irq_to_server_o`=0. An acknowledge with id 15 clears it.
- R8: `unimp_i` high reports vector 2012h and `trap_i` high reports vector 2010h, ahead of all other sources, with `unimp_i` ahead of `trap_i`. Both report id 0 and `irq_to_server_o`=0, and neither has a pending bit.
- R9: The receive flag drives line 9 when mask bit 9 is 1, and otherwise line 6. The transmit flag drives line 8 when mask bit 8 is 1, and otherwise line 6. The steered flags are ORed with `src_req_i`.
- R10: Register select codes are 0 for pending, 1 for mask, 2 for select and 3 for none, which reads zero and ignores writes. Reading pending returns the non-maskable flag in bit 15. Bit 15 reads 0 for mask and select. A write replaces bits 14..0 of the chosen register, and the acknowledge and edge rules of R2 then apply to pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 15 | Maskable request lines 0..14 |
| rx_flag_i | input | 1 | Serial receive flag, steered per R9 |
| tx_flag_i | input | 1 | Serial transmit flag, steered per R9 |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| unimp_i | input | 1 | Unimplemented-opcode exception request |
| trap_i | input | 1 | Software-trap exception request |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 4 | Source number being acknowledged |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 15 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 16 | Read data |
| irq_valid_o | output | 1 | A winner exists |
| irq_vector_o | output | 16 | Vector address of the winner |
| irq_to_server_o | output | 1 | Winner goes to the transaction server |
| irq_id_o | output | 4 | Source number of the winner |

## Verification
The bench builds the block with its default parameters: fifteen maskable lines, with lines 6, 8 and 9 serving the serial port. These are the values that make the vector formulas, the split between the two normal vector ranges at line 8 and the serial steering reachable. Directed sequences cover masked pending lines and server routing overriding a higher normal number. They also cover a held request that does not re-trigger, an edge that collides with an acknowledge, non-maskable and exception precedence, and both steering cases. A long random phase then mixes requests, register writes and acknowledges against the behavioural model.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VEC_W = 16;
    localparam int ID_W  = 4;
    localparam int IDX_W = 16;

    localparam logic [VEC_W-1:0] LOW_BASE  = 16'h2000;
    localparam logic [VEC_W-1:0] HIGH_BASE = 16'h2030;
    localparam logic [VEC_W-1:0] SRV_BASE  = 16'h2040;
    localparam logic [VEC_W-1:0] UNIMP_VEC = 16'h2012;
    localparam logic [VEC_W-1:0] TRAP_VEC  = 16'h2010;
    localparam logic [ID_W-1:0]  NMI_ID    = 4'd15;
    localparam logic [ID_W-1:0]  SPLIT_ID  = 4'd8;

    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_SEL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             to_server;
        logic [ID_W-1:0]  id;
        logic [VEC_W-1:0] vec;
    } pick_t;

    // Normal-routine vector for source n (two ranges split at source 8)
    function automatic logic [VEC_W-1:0] normal_vec(input logic [ID_W-1:0] n);
        logic [ID_W-1:0] off;
        if (n < SPLIT_ID) begin
            return LOW_BASE + {11'b0, n, 1'b0};
        end
        off = n - SPLIT_ID;
        return HIGH_BASE + {11'b0, off, 1'b0};
    endfunction

    function automatic logic [VEC_W-1:0] server_vec(input logic [ID_W-1:0] n);
        return SRV_BASE + {11'b0, n, 1'b0};
    endfunction

    // Returns {found, index of highest set bit}
    function automatic logic [ID_W:0] top_index(input logic [IDX_W-1:0] v);
        logic [ID_W:0] res;
        res = '0;
        for (int i = 0; i < IDX_W; i++) begin
            if (v[i]) res = {1'b1, ID_W'(i)};
        end
        return res;
    endfunction
endpackage

// File: rtl/irqv_steer.sv
module irqv_steer #(
    parameter int NUM_LINES = 15,
    parameter int COMB_IDX  = 6,
    parameter int TX_IDX    = 8,
    parameter int RX_IDX    = 9
) (
    input  logic [NUM_LINES-1:0] src_i,
    input  logic                 rx_i,
    input  logic                 tx_i,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] eff_o
);
    always_comb begin
        eff_o = src_i;
        if (mask_i[RX_IDX]) eff_o[RX_IDX]   = eff_o[RX_IDX] | rx_i;
        else                eff_o[COMB_IDX] = eff_o[COMB_IDX] | rx_i;
        if (mask_i[TX_IDX]) eff_o[TX_IDX]   = eff_o[TX_IDX] | tx_i;
        else                eff_o[COMB_IDX] = eff_o[COMB_IDX] | tx_i;
    end
endmodule

// File: rtl/irqv_state.sv
module irqv_state
    import irqv_pkg::*;
#(
    parameter int NUM_LINES = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] eff_i,
    input  logic                 nmi_i,
    input  logic                 wr_en_i,
    input  reg_sel_e             wr_sel_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    input  logic                 ack_i,
    input  logic [ID_W-1:0]      ack_id_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sel_o,
    output logic                 nmi_pend_o
);
    logic [NUM_LINES-1:0] pend_q, mask_q, sel_q, prev_q;
    logic [NUM_LINES-1:0] rise, ack_vec, pend_base, pend_d;
    logic                 nmi_prev_q, nmi_pend_q, nmi_rise, nmi_ack;
    logic                 pend_wr;

    assign rise     = eff_i & ~prev_q;
    assign nmi_rise = nmi_i & ~nmi_prev_q;
    assign nmi_ack  = ack_i && (ack_id_i == NMI_ID);
    assign pend_wr  = wr_en_i && (wr_sel_i == REG_PEND);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ack
        assign ack_vec[g] = ack_i && (ack_id_i == ID_W'(g));
    end

    assign pend_base = pend_wr ? wr_data_i : pend_q;
    assign pend_d    = (pend_base & ~ack_vec) | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            mask_q     <= '0;
            sel_q      <= '0;
            prev_q     <= '0;
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            pend_q     <= pend_d;
            prev_q     <= eff_i;
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= (nmi_pend_q & ~nmi_ack) | nmi_rise;
            if (wr_en_i && (wr_sel_i == REG_MASK)) mask_q <= wr_data_i;
            if (wr_en_i && (wr_sel_i == REG_SEL))  sel_q  <= wr_data_i;
        end
    end

    assign pend_o     = pend_q;
    assign mask_o     = mask_q;
    assign sel_o      = sel_q;
    assign nmi_pend_o = nmi_pend_q;

    // R2: every rising edge leaves its pending bit set
    p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R2: an acknowledged bit without a colliding edge or write is cleared
    p_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (!pend_wr) |=> ((pend_q & $past(ack_vec & ~rise)) == '0));

    // R7: an edge on the non-maskable input always raises its flag
    p_nmi_rise_r7: assert property (@(posedge clk) disable iff (rst)
        nmi_rise |=> nmi_pend_q);
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick
    import irqv_pkg::*;
#(
    parameter int NUM_LINES = 15
) (
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] sel_i,
    input  logic                 nmi_pend_i,
    input  logic                 unimp_i,
    input  logic                 trap_i,
    output pick_t                pick_o
);
    localparam int PAD = IDX_W - NUM_LINES;

    logic [NUM_LINES-1:0] live, srv_live, nrm_live;
    logic [ID_W:0]        srv_top, nrm_top;

    assign live     = pend_i & mask_i;
    assign srv_live = live & sel_i;
    assign nrm_live = live & ~sel_i;
    assign srv_top  = top_index({{PAD{1'b0}}, srv_live});
    assign nrm_top  = top_index({{PAD{1'b0}}, nrm_live});

    always_comb begin
        pick_o = '0;
        if (unimp_i) begin
            pick_o.valid = 1'b1;
            pick_o.vec   = UNIMP_VEC;
        end else if (trap_i) begin
            pick_o.valid = 1'b1;
            pick_o.vec   = TRAP_VEC;
        end else if (nmi_pend_i) begin
            pick_o.valid = 1'b1;
            pick_o.id    = NMI_ID;
            pick_o.vec   = normal_vec(NMI_ID);
        end else if (srv_top[ID_W]) begin
            pick_o.valid     = 1'b1;
            pick_o.to_server = 1'b1;
            pick_o.id        = srv_top[ID_W-1:0];
            pick_o.vec       = server_vec(srv_top[ID_W-1:0]);
        end else if (nrm_top[ID_W]) begin
            pick_o.valid = 1'b1;
            pick_o.id    = nrm_top[ID_W-1:0];
            pick_o.vec   = normal_vec(nrm_top[ID_W-1:0]);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int COMB_IDX  = 6,
    parameter int TX_IDX    = 8,
    parameter int RX_IDX    = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] src_req_i,
    input  logic                 rx_flag_i,
    input  logic                 tx_flag_i,
    input  logic                 nmi_i,
    input  logic                 unimp_i,
    input  logic                 trap_i,
    input  logic                 ack_i,
    input  logic [3:0]           ack_id_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    input  logic [1:0]           rd_sel_i,
    output logic [NUM_LINES:0]   rd_data_o,
    output logic                 irq_valid_o,
    output logic [15:0]          irq_vector_o,
    output logic                 irq_to_server_o,
    output logic [3:0]           irq_id_o
);
    localparam int DATA_W = NUM_LINES + 1;

    logic [NUM_LINES-1:0] eff, pend, mask, sel;
    logic                 nmi_pend;
    pick_t                pick_d, pick_q;

    irqv_steer #(
        .NUM_LINES(NUM_LINES), .COMB_IDX(COMB_IDX),
        .TX_IDX(TX_IDX), .RX_IDX(RX_IDX)
    ) u_steer (
        .src_i(src_req_i), .rx_i(rx_flag_i), .tx_i(tx_flag_i),
        .mask_i(mask), .eff_o(eff)
    );

    irqv_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk(clk), .rst(rst), .eff_i(eff), .nmi_i(nmi_i),
        .wr_en_i(wr_en_i), .wr_sel_i(reg_sel_e'(wr_sel_i)), .wr_data_i(wr_data_i),
        .ack_i(ack_i), .ack_id_i(ack_id_i),
        .pend_o(pend), .mask_o(mask), .sel_o(sel), .nmi_pend_o(nmi_pend)
    );

    irqv_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .pend_i(pend), .mask_i(mask), .sel_i(sel), .nmi_pend_i(nmi_pend),
        .unimp_i(unimp_i), .trap_i(trap_i), .pick_o(pick_d)
    );

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_d;
    end

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            REG_PEND: rd_data_o = {nmi_pend, pend};
            REG_MASK: rd_data_o = {1'b0, mask};
            REG_SEL:  rd_data_o = {1'b0, sel};
            default:  rd_data_o = DATA_W'(0);
        endcase
    end

    assign irq_valid_o     = pick_q.valid;
    assign irq_vector_o    = pick_q.vec;
    assign irq_to_server_o = pick_q.to_server;
    assign irq_id_o        = pick_q.id;

    // R8: the unimplemented-opcode request is reported at the next edge
    p_unimp_first_r8: assert property (@(posedge clk) disable iff (rst)
        $past(unimp_i) |-> (irq_valid_o && irq_vector_o == UNIMP_VEC && !irq_to_server_o));

    // R7: a raised non-maskable flag wins unless an exception is present
    p_nmi_top_r7: assert property (@(posedge clk) disable iff (rst)
        $past(nmi_pend && !unimp_i && !trap_i) |-> (irq_vector_o == 16'h203E && irq_id_o == NMI_ID));

    // R6: a server winner always carries a vector in the server range
    p_server_range_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && irq_to_server_o) |-> (irq_vector_o >= SRV_BASE && irq_vector_o < 16'h205E));

    // R4: no enabled pending source and no exception means no winner
    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        $past(((pend & mask) == '0) && !nmi_pend && !unimp_i && !trap_i) |-> !irq_valid_o);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] src_req_i = '0;
    logic        rx_flag_i = 1'b0, tx_flag_i = 1'b0, nmi_i = 1'b0;
    logic        unimp_i = 1'b0, trap_i = 1'b0, ack_i = 1'b0, wr_en_i = 1'b0;
    logic [3:0]  ack_id_i = '0;
    logic [1:0]  wr_sel_i = '0, rd_sel_i = '0;
    logic [14:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_valid_o, irq_to_server_o;
    logic [15:0] irq_vector_o;
    logic [3:0]  irq_id_o;

    int checks = 0, failures = 0;
    bit started = 0, done = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .src_req_i(src_req_i), .rx_flag_i(rx_flag_i),
        .tx_flag_i(tx_flag_i), .nmi_i(nmi_i), .unimp_i(unimp_i), .trap_i(trap_i),
        .ack_i(ack_i), .ack_id_i(ack_id_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .irq_valid_o(irq_valid_o), .irq_vector_o(irq_vector_o),
        .irq_to_server_o(irq_to_server_o), .irq_id_o(irq_id_o)
    );

    // ---------------- behavioural reference model ----------------
    bit [14:0] m_pend, m_mask, m_sel, m_prev;
    bit        m_nmi, m_nmi_prev;
    bit [21:0] exp_out;   // {valid, server, id[3:0], vec[15:0]}
    string     exp_tag = "R1";

    always @(posedge clk) begin
        bit [14:0] eff, base;
        int bs, bn;
        started = 1;
        if (rst) begin
            m_pend = 0; m_mask = 0; m_sel = 0; m_prev = 0;
            m_nmi = 0; m_nmi_prev = 0; exp_out = 0; exp_tag = "R1";
        end else begin
            // expected outputs from the state held before this edge
            bs = -1; bn = -1;
            for (int n = 0; n < 15; n++)
                if (m_pend[n] && m_mask[n]) begin
                    if (m_sel[n]) bs = n; else bn = n;
                end
            if (unimp_i)      begin exp_out = {1'b1, 1'b0, 4'd0, 16'h2012}; exp_tag = "R8"; end
            else if (trap_i)  begin exp_out = {1'b1, 1'b0, 4'd0, 16'h2010}; exp_tag = "R8"; end
            else if (m_nmi)   begin exp_out = {1'b1, 1'b0, 4'd15, 16'h203E}; exp_tag = "R7"; end
            else if (bs >= 0) begin
                exp_out = {1'b1, 1'b1, 4'(bs), 16'(32'h2040 + 2 * bs)}; exp_tag = "R6";
            end else if (bn >= 0) begin
                exp_out = {1'b1, 1'b0, 4'(bn),
                           16'((bn < 8) ? (32'h2000 + 2 * bn) : (32'h2030 + 2 * (bn - 8)))};
                exp_tag = "R5";
            end else begin exp_out = 0; exp_tag = "R4"; end

            // state update
            eff = src_req_i;
            if (m_mask[9]) eff[9] = eff[9] | rx_flag_i; else eff[6] = eff[6] | rx_flag_i;
            if (m_mask[8]) eff[8] = eff[8] | tx_flag_i; else eff[6] = eff[6] | tx_flag_i;
            base = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i : m_pend;
            if (ack_i && ack_id_i < 15) base[ack_id_i] = 1'b0;
            m_pend = base | (eff & ~m_prev);
            m_prev = eff;
            if (ack_i && ack_id_i == 15) m_nmi = 0;
            if (nmi_i && !m_nmi_prev) m_nmi = 1;
            m_nmi_prev = nmi_i;
            if (wr_en_i && wr_sel_i == 2'd1) m_mask = wr_data_i;
            if (wr_en_i && wr_sel_i == 2'd2) m_sel = wr_data_i;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if ({irq_valid_o, irq_to_server_o, irq_id_o, irq_vector_o} !== exp_out) begin
                failures++;
                $display("FAIL %s cycle compare: actual v=%0b s=%0b id=%0d vec=%h expected v=%0b s=%0b id=%0d vec=%h",
                         exp_tag, irq_valid_o, irq_to_server_o, irq_id_o, irq_vector_o,
                         exp_out[21], exp_out[20], exp_out[19:16], exp_out[15:0]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] s, input logic [14:0] d);
        wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
        step();
        wr_en_i = 0;
    endtask

    task automatic ack(input logic [3:0] id);
        ack_i = 1; ack_id_i = id;
        step();
        ack_i = 0;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        rd_sel_i = s; #1; v = rd_data_o;
    endtask

    task automatic out_chk(input string tag, input int v, input int s, input int id, input int vec);
        chk(tag, {irq_valid_o, irq_to_server_o, irq_id_o, irq_vector_o}, {v[0], s[0], id[3:0], vec[15:0]});
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int r;
        repeat (3) step();
        rst = 0;
        // R1: reset state
        rd(2'd0, r); chk("R1 pending", r, 0);
        rd(2'd1, r); chk("R1 mask", r, 0);
        rd(2'd2, r); chk("R1 select", r, 0);
        chk("R1 valid", irq_valid_o, 0);

        // R2: edge on line 3 sets pending; R4: masked so no winner
        src_req_i[3] = 1; step();
        rd(2'd0, r); chk("R2 edge sets", r, 16'h0008);
        step(); chk("R4 masked line", irq_valid_o, 0);

        // R3: enabling the mask shows up one clock later
        wr(2'd1, 15'h0008);
        chk("R3 not yet", irq_valid_o, 0);
        step(); out_chk("R5 vec line 3", 1, 0, 3, 16'h2006);

        // R4: higher number wins
        src_req_i[5] = 1; wr(2'd1, 15'h0028); step();
        out_chk("R4 line 5 over 3", 1, 0, 5, 16'h200A);
        src_req_i[12] = 1; wr(2'd1, 15'h1028); step();
        out_chk("R5 vec line 12", 1, 0, 12, 16'h2038);

        // R2: ack with request held high does not re-trigger
        ack(4'd12);
        rd(2'd0, r); chk("R2 held no retrigger", r & 16'h1000, 0);
        step(); out_chk("R4 back to line 5", 1, 0, 5, 16'h200A);

        // R2: new edge colliding with ack keeps the bit
        src_req_i[5] = 0; step();
        src_req_i[5] = 1; ack(4'd5);
        rd(2'd0, r); chk("R2 edge beats ack", r & 16'h0020, 16'h0020);

        // R6: server-routed line 3 beats normal line 5
        wr(2'd2, 15'h0008); step();
        out_chk("R6 server wins", 1, 1, 3, 16'h2046);

        // R7: non-maskable beats all maskable
        nmi_i = 1; step(); step();
        out_chk("R7 nmi wins", 1, 0, 15, 16'h203E);
        rd(2'd0, r); chk("R10 nmi bit 15", r & 16'h8000, 16'h8000);
        ack(4'd15); step();
        out_chk("R7 nmi acked", 1, 1, 3, 16'h2046);

        // R8: exceptions
        unimp_i = 1; step(); out_chk("R8 unimp", 1, 0, 0, 16'h2012);
        trap_i = 1; step(); out_chk("R8 unimp over trap", 1, 0, 0, 16'h2012);
        unimp_i = 0; step(); out_chk("R8 trap", 1, 0, 0, 16'h2010);
        trap_i = 0;

        // R9: serial steering
        src_req_i = 0; nmi_i = 0;
        wr(2'd0, 15'h0); wr(2'd2, 15'h0); wr(2'd1, 15'h0040);
        rx_flag_i = 1; step();
        rd(2'd0, r); chk("R9 rx to combined", r, 16'h0040);
        rx_flag_i = 0; step(); wr(2'd0, 15'h0); wr(2'd1, 15'h0300);
        tx_flag_i = 1; step();
        rd(2'd0, r); chk("R9 tx separate", r, 16'h0100);
        rx_flag_i = 1; step();
        rd(2'd0, r); chk("R9 rx separate", r, 16'h0300);
        rx_flag_i = 0; tx_flag_i = 0;

        // R10: register access
        wr(2'd0, 15'h4001);
        rd(2'd0, r); chk("R10 pending write", r, 16'h4001);
        rd(2'd1, r); chk("R10 mask read", r, 16'h0300);
        wr(2'd3, 15'h7FFF);
        rd(2'd3, r); chk("R10 select 3 reads zero", r, 0);
        rd(2'd1, r); chk("R10 select 3 write ignored", r, 16'h0300);

        // random phase: model compared every cycle (R2..R10)
        for (int i = 0; i < 3000; i++) begin
            src_req_i = 15'($urandom) & 15'($urandom) & 15'($urandom);
            rx_flag_i = ($urandom % 4) == 0;
            tx_flag_i = ($urandom % 4) == 0;
            nmi_i     = ($urandom % 16) == 0;
            unimp_i   = ($urandom % 40) == 0;
            trap_i    = ($urandom % 40) == 0;
            wr_en_i   = ($urandom % 6) == 0;
            wr_sel_i  = 2'($urandom);
            wr_data_i = 15'($urandom);
            ack_i     = irq_valid_o && (($urandom % 2) == 0);
            ack_id_i  = ($urandom % 8 == 0) ? 4'($urandom) : irq_id_o;
            rd_sel_i  = 2'($urandom);
            step();
        end
        wr_en_i = 0; ack_i = 0;
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule